// File: doc/BRIEF.md
# Bidirectional Loadable Counter Stage

A binary counter stage of parameterized width that counts up or down on each rising clock edge when its count enable is high. A synchronous parallel load takes priority over counting and works even when the count enable is low. An active-low clear, asynchronous in its assertion, empties the stage at once and overrides every other input.

The stage decodes a terminal count that depends on the direction. Counting up, the terminal count is reached at all ones. Counting down, it is reached at all zeros. The stage also drives an enable-out, which is the terminal count gated by the stage's own count enable. Stages are chained by feeding each enable-out into the next stage's count enable, with clock, direction, load and clear shared by all of them. The chain then behaves as one wide counter whose low stage holds the least significant bits.

Top module: `bidir_load_counter`

## Requirements
- R1: While `aclr_n` is low, `q` is all zeros and both `tc` and `ceo` are 0. This takes effect without waiting for a clock edge, and it overrides load, count enable and direction.
- R2: With `aclr_n` high and `load` high at a rising edge, `q` takes the value of `din`, whatever the level of `cnt_en`.
- R3: With `load` low, `cnt_en` high and `dir_up` high at a rising edge, `q` increments by one modulo 2^WIDTH (all ones wraps to zero).
- R4: With `load` low, `cnt_en` high and `dir_up` low at a rising edge, `q` decrements by one modulo 2^WIDTH (zero wraps to all ones).
- R5: With `load` low and `cnt_en` low, a rising edge leaves `q` unchanged, whatever the level of `dir_up`.
- R6: `tc` is combinational. It is 1 when `dir_up` is 1 and every bit of `q` is 1, or when `dir_up` is 0 and every bit of `q` is 0. Otherwise it is 0.
- R7: `ceo` is 1 exactly when `tc` and `cnt_en` are both 1.
- R8: Stages can be chained: the first stage's count enable is the chain's enable, each later stage takes the previous stage's `ceo`, and the concatenated outputs (stage 0 least significant) count, load, hold and clear as one counter of the combined width. The last stage's `ceo` is the chain's carry out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| aclr_n | input | 1 | Active-low clear, asynchronous assertion |
| load | input | 1 | Synchronous parallel load enable |
| cnt_en | input | 1 | Count enable (connect to previous stage's `ceo` when chained) |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| tc | output | 1 | Direction-qualified terminal count |
| ceo | output | 1 | Enable out: `tc` gated by `cnt_en` |

## Verification
The assertions assume that `aclr_n` is released at a point well away from a rising clock edge. They also assume that `load`, `cnt_en`, `dir_up` and `din` are settled before each edge, so that each property can relate the value sampled at one edge to `q` at the next. The stimulus meets both conditions: every input, the clear included, is changed only on the falling clock edge. A chain of four 4-bit stages is then checked against a wide reference count. The clear is asserted in the middle of a count and held across an edge. Loads are applied with the enable both low and high. Finally, a long mix of direction, enable and load patterns is run through the chain.

// File: rtl/bdc_pkg.sv
`timescale 1ns/1ps
package bdc_pkg;

  typedef enum logic [1:0] {
    BDC_HOLD = 2'd0,
    BDC_LOAD = 2'd1,
    BDC_UP   = 2'd2,
    BDC_DOWN = 2'd3
  } bdc_op_e;

  // Load outranks counting; counting needs the enable; direction picks the sign.
  function automatic bdc_op_e bdc_decode(input logic ld, input logic en, input logic up);
    if (ld)      return BDC_LOAD;
    else if (!en) return BDC_HOLD;
    else if (up)  return BDC_UP;
    else          return BDC_DOWN;
  endfunction

endpackage

// File: rtl/bdc_step.sv
`timescale 1ns/1ps
module bdc_step
  import bdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bdc_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    nxt = cur;
    upd = 1'b1;
    unique case (op)
      BDC_LOAD: nxt = din;
      BDC_UP:   nxt = cur + ONE;   // wraps modulo 2^WIDTH
      BDC_DOWN: nxt = cur - ONE;   // wraps modulo 2^WIDTH
      default:  upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/bdc_term.sv
`timescale 1ns/1ps
module bdc_term #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dir_up,
  input  logic             live,
  output logic             tc
);

  logic all_ones;
  logic all_zeros;

  always_comb begin
    all_ones  = 1'b1;
    all_zeros = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      all_ones  = all_ones  & cur[i];
      all_zeros = all_zeros & ~cur[i];
    end
  end

  // Gated by live so that a cleared, down-counting stage does not flag zero.
  assign tc = live & (dir_up ? all_ones : all_zeros);

endmodule

// File: rtl/bidir_load_counter.sv
`timescale 1ns/1ps
module bidir_load_counter
  import bdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             aclr_n,
  input  logic             load,
  input  logic             cnt_en,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc,
  output logic             ceo
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

  bdc_op_e          op;
  logic [WIDTH-1:0] cnt_nxt;
  logic             cnt_upd;

  assign op = bdc_decode(load, cnt_en, dir_up);

  bdc_step #(.WIDTH(WIDTH)) u_step (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (cnt_nxt),
    .upd (cnt_upd)
  );

  // Register with explicit enable; clear is asynchronous and dominant.
  always_ff @(posedge clk or negedge aclr_n) begin
    if (!aclr_n)      q <= '0;
    else if (cnt_upd) q <= cnt_nxt;
  end

  bdc_term #(.WIDTH(WIDTH)) u_term (
    .cur    (q),
    .dir_up (dir_up),
    .live   (aclr_n),
    .tc     (tc)
  );

  assign ceo = tc & cnt_en;

  // ---------------- assertions ----------------
  always @(posedge clk) begin
    if (!aclr_n) begin
      a_r1_clear_forces_zero: assert (q == '0 && !tc && !ceo)
        else $error("R1: outputs not zero under clear");
    end
  end

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!aclr_n)
    load |=> q == $past(din))
    else $error("R2: load did not capture din");

  a_r3_increment: assert property (@(posedge clk) disable iff (!aclr_n)
    (!load && cnt_en && dir_up) |=> q == $past(q) + ONE)
    else $error("R3: increment wrong");

  a_r4_decrement: assert property (@(posedge clk) disable iff (!aclr_n)
    (!load && cnt_en && !dir_up) |=> q == $past(q) - ONE)
    else $error("R4: decrement wrong");

  a_r5_hold: assert property (@(posedge clk) disable iff (!aclr_n)
    (!load && !cnt_en) |=> $stable(q))
    else $error("R5: count moved with enable low");

  a_r7_up_carry_wraps: assert property (@(posedge clk) disable iff (!aclr_n)
    (ceo && !load && dir_up) |=> q == '0)
    else $error("R7: up carry not followed by zero");

  a_r7_down_borrow_wraps: assert property (@(posedge clk) disable iff (!aclr_n)
    (ceo && !load && !dir_up) |=> q == ALL1)
    else $error("R7: down borrow not followed by all ones");

endmodule

// File: tb/sim_bidir_load_counter.sv
`timescale 1ns/1ps
module sim_bidir_load_counter;

  localparam int  SW  = 4;
  localparam int  NS  = 4;
  localparam int  TW  = SW * NS;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic          aclr_n, load, en, up;
  logic [TW-1:0] din;
  logic [SW-1:0] qs [NS];
  logic [NS-1:0] tcs, ceos;
  logic [TW-1:0] q_all;

  assign q_all = {qs[3], qs[2], qs[1], qs[0]};

  bidir_load_counter #(.WIDTH(SW)) u0 (
    .clk(clk), .aclr_n(aclr_n), .load(load), .cnt_en(en), .dir_up(up),
    .din(din[3:0]), .q(qs[0]), .tc(tcs[0]), .ceo(ceos[0]));
  bidir_load_counter #(.WIDTH(SW)) u1 (
    .clk(clk), .aclr_n(aclr_n), .load(load), .cnt_en(ceos[0]), .dir_up(up),
    .din(din[7:4]), .q(qs[1]), .tc(tcs[1]), .ceo(ceos[1]));
  bidir_load_counter #(.WIDTH(SW)) u2 (
    .clk(clk), .aclr_n(aclr_n), .load(load), .cnt_en(ceos[1]), .dir_up(up),
    .din(din[11:8]), .q(qs[2]), .tc(tcs[2]), .ceo(ceos[2]));
  bidir_load_counter #(.WIDTH(SW)) u3 (
    .clk(clk), .aclr_n(aclr_n), .load(load), .cnt_en(ceos[2]), .dir_up(up),
    .din(din[15:12]), .q(qs[3]), .tc(tcs[3]), .ceo(ceos[3]));

  typedef struct {
    logic [TW-1:0] q;
    logic          en;
    logic          up;
    logic          clr;
    string         tag;
  } exp_t;

  exp_t          sb [$];
  int            n_cmp = 0;
  int            n_bad = 0;
  logic [TW-1:0] model;
  bit            done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one call per clock; drives at the falling edge, queues the expectation.
  task automatic step(bit clr, bit ld, bit ce, bit dir, logic [TW-1:0] d, string tag);
    @(negedge clk);
    aclr_n = ~clr; load = ld; en = ce; up = dir; din = d;
    if (clr)      model = '0;
    else if (ld)  model = d;
    else if (ce)  model = dir ? TW'(model + 1) : TW'(model - 1);
    sb.push_back('{model, ce, dir, clr, tag});
    if (clr) begin
      #2;
      check("R1 async clear count", {16'h0, q_all}, 32'h0);
      check("R1 async clear tc/ceo", {24'h0, tcs, ceos}, 32'h0);
    end
  endtask

  // Monitor: samples mid-cycle after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        logic tc0, cout;
        e    = sb.pop_front();
        tc0  = e.clr ? 1'b0 : (e.up ? (e.q[3:0] == 4'hF) : (e.q[3:0] == 4'h0));
        cout = e.clr ? 1'b0 : (e.en & (e.up ? (e.q == 16'hFFFF) : (e.q == 16'h0000)));
        check(e.tag, {16'h0, q_all}, {16'h0, e.q});
        check("R6 stage terminal count", {31'h0, tcs[0]}, {31'h0, tc0});
        check("R7 stage enable out", {31'h0, ceos[0]}, {31'h0, tc0 & e.en});
        check("R8 chain carry out", {31'h0, ceos[3]}, {31'h0, cout});
      end
    end
  end

  initial begin
    aclr_n = 1'b0; load = 1'b0; en = 1'b0; up = 1'b1; din = '0; model = '0;
    step(1, 0, 0, 1, 16'h0000, "R1 reset state");
    step(1, 1, 1, 1, 16'h1234, "R1 clear beats load");
    step(0, 1, 0, 1, 16'h0FFD, "R2 load with enable low");
    repeat (5) step(0, 0, 1, 1, 16'h0, "R3 R8 up across stages");
    step(0, 1, 0, 0, 16'hFFFE, "R2 load while down");
    repeat (3) step(0, 0, 1, 1, 16'h0, "R3 up wrap");
    repeat (3) step(0, 0, 1, 0, 16'h0, "R4 down wrap");
    repeat (2) step(0, 0, 0, 0, 16'h0, "R5 hold");
    step(0, 0, 0, 1, 16'h0, "R5 hold with direction flip");
    step(0, 1, 1, 0, 16'h1000, "R2 load with enable high");
    step(0, 0, 1, 0, 16'h0, "R4 R8 borrow across stages");
    repeat (7) step(0, 0, 1, 1, 16'h0, "R3 count");
    step(1, 0, 1, 1, 16'h0, "R1 clear mid count");
    step(1, 0, 1, 0, 16'h0, "R1 clear held over edge");
    step(0, 0, 1, 0, 16'h0, "R4 down from cleared");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(0, r[3:0] == 4'h0, r[4] | r[5], r[6], r[31:16], "R8 mixed pattern");
    end
    @(posedge clk);
    @(posedge clk);
    #6;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(TCK * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule